// File: doc/BRIEF.md
# Entropy Conditioning CRC Accumulator

This block turns three raw noise bit streams into a 64-bit conditioned random word. In every clock cycle it samples one bit from each source and masks off the sources whose enable bits are clear. It XORs the remaining bits into a single bit and shifts that bit into a 64-bit CRC register built on a fixed dense generator polynomial. The CRC register is the random word. Software can read it but cannot write it.

A control register holds the three source enables, an interlock mode bit and a wait count. When the interlock is on, a read request is held off until the wait count of cycles has passed since the previous completed read. This gives enough fresh noise to fold into the word before it is handed out again. When the interlock is off, every request completes at once. The usual setting is all three sources enabled, the interlock on, and a wait count sized to the word width.

Top module: `entropy_crc_accum`

## Requirements
- R1: After reset, the control register reads 0 (all sources off, interlock off, wait 0), `rd_valid` is 0, `rd_data` is 0, and the accumulator holds 0.
- R2: When `cfg_we` is high at a clock edge, `cfg_wdata` is loaded into the control register, and `cfg_q` shows it from the next cycle. The field layout is: bits [2:0] enable sources 0..2 (bit i enables `src_bit[i]`), bit 3 is the interlock mode, and bits [19:4] are the wait count.
- R3: The bit fed to the accumulator in a cycle is the XOR of `src_bit[i] & enable[i]` over the three sources. A disabled source has no effect on the accumulated word.
- R4: At every clock edge, the accumulator becomes `{acc[62:0],0}`, XORed with the 64-bit constant of the polynomial x^64+x^61+x^57+x^56+x^52+x^51+x^50+x^48+x^47+x^46+x^43+x^42+x^41+x^39+x^38+x^37+x^35+x^32+x^28+x^25+x^22+x^21+x^17+x^15+x^13+x^12+x^11+x^7+x^5+x+1 (without the x^64 term) whenever `acc[63]` XOR the input bit is 1.
- R5: With all sources disabled, the accumulator still advances every cycle, with input 0. A zero accumulator stays zero.
- R6: A request granted in a cycle raises `rd_valid` for exactly the next cycle. In that cycle `rd_data` holds the accumulator value of the granted cycle. `rd_valid` is never high without a request in the cycle before.
- R7: With interlock mode clear, every cycle with `rd_req` high is granted.
- R8: With interlock mode set, a request is granted only when at least the wait count of cycles has passed since the last grant (or since reset). If the request is held high, grants are exactly wait+1 cycles apart. A request after a long idle period is granted at once.
- R9: With interlock mode set and wait 0, a held request is granted every cycle.
- R10: `rd_data` keeps its value in every cycle in which `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_bit | input | 3 | One raw noise bit per source, sampled every cycle |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 20 | New control register value |
| cfg_q | output | 20 | Current control register value |
| rd_req | input | 1 | Read request, held until served |
| rd_valid | output | 1 | One-cycle pulse marking a completed read |
| rd_data | output | 64 | Random word captured by the last completed read |

## Verification
The assertions take these inputs as given:
- `src_bit`, `rd_req` and the control write inputs are known (not X) once reset is released.
- The wait field only changes through a synchronous write.

The interlock gap check compares against the wait value of the cycle in which the grant happened. It is therefore valid even when the wait field is rewritten between two reads.

The stimulus drives every input half a period away from the rising edge and never leaves an input undriven. It rewrites the control register only at chosen points: during the table walk with the interlock off, and once before each interlock pattern (wait 5, then wait 0).

// File: rtl/ent_pkg.sv
package ent_pkg;
  localparam int ACC_W = 64;
  // Generator constant; the x^64 term is implicit in the shift-out bit.
  localparam logic [ACC_W-1:0] GEN_CONST = 64'h231D_CEE9_1262_B8A3;

  function automatic logic [ACC_W-1:0] acc_advance(input logic [ACC_W-1:0] cur,
                                                   input logic din);
    logic fb;
    fb = cur[ACC_W-1] ^ din;
    return {cur[ACC_W-2:0], 1'b0} ^ (fb ? GEN_CONST : '0);
  endfunction
endpackage

// File: rtl/ent_mixer.sv
module ent_mixer #(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0] src_bit,
  input  logic [NSRC-1:0] src_en,
  output logic            mix_bit
);
  logic [NSRC-1:0] gated;

  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    assign gated[i] = src_bit[i] & src_en[i];
  end

  assign mix_bit = ^gated;
endmodule

// File: rtl/ent_crc_reg.sv
module ent_crc_reg
  import ent_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  output logic [ACC_W-1:0] acc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_advance(acc_q, din);
  end
endmodule

// File: rtl/ent_read_gate.sv
module ent_read_gate #(
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              lock_on,
  input  logic [WAIT_W-1:0] wait_cyc,
  output logic              grant
);
  localparam logic [WAIT_W-1:0] CNT_MAX = '1;

  logic [WAIT_W-1:0] since_q;
  logic              open;

  assign open  = !lock_on || (since_q >= wait_cyc);
  assign grant = req && open;

  always_ff @(posedge clk) begin
    if (!rst_n)                  since_q <= '0;
    else if (grant)              since_q <= '0;
    else if (since_q != CNT_MAX) since_q <= since_q + 1'b1;
  end
endmodule

// File: rtl/entropy_crc_accum.sv
module entropy_crc_accum
  import ent_pkg::*;
#(
  parameter int NSRC   = 3,
  parameter int WAIT_W = 16,
  localparam int CFG_W = NSRC + 1 + WAIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_bit,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_q,
  input  logic             rd_req,
  output logic             rd_valid,
  output logic [ACC_W-1:0] rd_data
);
  localparam int MODE_BIT = NSRC;
  localparam int WAIT_LO  = NSRC + 1;

  logic [CFG_W-1:0]  ctl_q;
  logic [NSRC-1:0]   ctl_en;
  logic              ctl_mode;
  logic [WAIT_W-1:0] ctl_wait;
  logic              mix_bit;
  logic [ACC_W-1:0]  crc_q;
  logic              rd_grant;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (cfg_we) ctl_q <= cfg_wdata;
  end

  assign ctl_en   = ctl_q[NSRC-1:0];
  assign ctl_mode = ctl_q[MODE_BIT];
  assign ctl_wait = ctl_q[CFG_W-1:WAIT_LO];
  assign cfg_q    = ctl_q;

  ent_mixer #(.NSRC(NSRC)) u_mix (
    .src_bit (src_bit),
    .src_en  (ctl_en),
    .mix_bit (mix_bit)
  );

  ent_crc_reg u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (mix_bit),
    .acc_q (crc_q)
  );

  ent_read_gate #(.WAIT_W(WAIT_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (rd_req),
    .lock_on  (ctl_mode),
    .wait_cyc (ctl_wait),
    .grant    (rd_grant)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_grant;
      if (rd_grant) rd_data <= crc_q;
    end
  end
endmodule

// File: rtl/entropy_crc_accum_chk.sv
module entropy_crc_accum_chk #(
  parameter int WAIT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [63:0]       rd_data,
  input logic              mode_q,
  input logic [WAIT_W-1:0] wait_q,
  input logic [63:0]       crc_q,
  input logic              mix_bit
);
  localparam logic [WAIT_W:0] GAP_MAX = '1;

  // Cycles since the last rd_valid pulse (or since reset), counted independently.
  logic [WAIT_W:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                gap_q <= '0;
    else if (rd_valid)         gap_q <= 1;
    else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
  end

  assert_zero_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(crc_q) == 64'd0 && $past(mix_bit) == 1'b0) |-> crc_q == 64'd0);

  assert_req_before_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req));

  assert_open_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !mode_q) |=> rd_valid);

  assert_interlock_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(mode_q)) |-> gap_q > {1'b0, $past(wait_q)});

  assert_no_backtoback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && mode_q && wait_q != '0) |=> !rd_valid);

  assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));
endmodule

bind entropy_crc_accum entropy_crc_accum_chk #(.WAIT_W(WAIT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_req   (rd_req),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .mode_q   (ctl_mode),
  .wait_q   (ctl_wait),
  .crc_q    (crc_q),
  .mix_bit  (mix_bit)
);

// File: tb/test_entropy_crc_accum.sv
`timescale 1ns/1ps
module test_entropy_crc_accum;
  localparam int CLK_HALF = 10;
  // Table entries: {enables[2:0], source bits[2:0]}
  localparam logic [5:0] VEC [12] = '{
    6'b111_101, 6'b111_011, 6'b001_001, 6'b001_111,
    6'b010_010, 6'b100_110, 6'b000_111, 6'b000_000,
    6'b011_011, 6'b101_100, 6'b110_110, 6'b111_111
  };
  localparam int EXPS [30] = '{61,57,56,52,51,50,48,47,46,43,42,41,39,38,37,
                               35,32,28,25,22,21,17,15,13,12,11,7,5,1,0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_bit = '0;
  logic        cfg_we = 1'b0;
  logic [19:0] cfg_wdata = '0;
  logic [19:0] cfg_q;
  logic        rd_req = 1'b0;
  logic        rd_valid;
  logic [63:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  logic [63:0] gen;
  logic [63:0] model = '0;
  logic [63:0] model_before = '0;
  logic [19:0] cur_cfg = '0;

  entropy_crc_accum i_entropy_crc_accum (
    .clk(clk), .rst_n(rst_n), .src_bit(src_bit), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #(CLK_HALF) clk = ~clk;

  function automatic logic [63:0] step_model(input logic [63:0] v, input logic b);
    logic top;
    top = v[63];
    v = v << 1;
    if (top != b) v = v ^ gen;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_before = model;
    if (rst_n) model = step_model(model, ^(src_bit & cur_cfg[2:0]));
    if (rst_n && cfg_we) cur_cfg = cfg_wdata;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_HALF * 2 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    gen = '0;
    foreach (EXPS[k]) gen[EXPS[k]] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(cfg_q == 20'd0, "R1 cfg_q", {44'd0, cfg_q}, 64'd0);
    check(rd_valid == 1'b0, "R1 rd_valid", {63'd0, rd_valid}, 64'd0);
    check(rd_data == 64'd0, "R1 rd_data", rd_data, 64'd0);

    // R5: all sources off after reset, the accumulator stays zero
    src_bit = 3'b111;
    rd_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cyc();
      check(rd_valid && rd_data == 64'd0, "R5 zero accumulation", rd_data, 64'd0);
    end

    // Table walk, interlock off: R2 R3 R4 R6 R7
    foreach (VEC[v]) begin
      cfg_wdata = {16'd0, 1'b0, VEC[v][5:3]};
      cfg_we = 1'b1;
      src_bit = VEC[v][2:0];
      cyc();
      cfg_we = 1'b0;
      check(cfg_q == cfg_wdata, "R2 cfg write", {44'd0, cfg_q}, {44'd0, cfg_wdata});
      check(rd_valid == 1'b1, "R7 grant each cycle", {63'd0, rd_valid}, 64'd1);
      check(rd_data == model_before, "R6 data capture", rd_data, model_before);
      for (int j = 0; j < 3; j++) begin
        cyc();
        check(rd_data == model_before, "R3 R4 accumulate", rd_data, model_before);
      end
    end

    // R8: interlock on, wait 5, held request
    begin
      int last;
      int seen;
      last = -1;
      seen = 0;
      cfg_wdata = {16'd5, 1'b1, 3'b111};
      cfg_we = 1'b1;
      src_bit = 3'b101;
      for (int c = 0; c < 40; c++) begin
        cyc();
        cfg_we = 1'b0;
        src_bit = {src_bit[1:0], src_bit[2] ^ src_bit[0]};
        if (rd_valid) begin
          check(rd_data == model_before, "R8 data on grant", rd_data, model_before);
          if (last >= 0)
            check(c - last == 6, "R8 grant spacing", 64'(c - last), 64'd6);
          last = c;
          seen++;
        end
      end
      check(seen >= 6, "R8 grant count", 64'(seen), 64'd6);
    end

    // R10: idle, data held; R8: a request after a long idle is granted at once
    rd_req = 1'b0;
    cyc();
    begin
      logic [63:0] held;
      held = rd_data;
      for (int c = 0; c < 12; c++) begin
        cyc();
        check(!rd_valid && rd_data == held, "R10 hold when idle", rd_data, held);
      end
    end
    rd_req = 1'b1;
    cyc();
    check(rd_valid == 1'b1, "R8 immediate after idle", {63'd0, rd_valid}, 64'd1);
    check(rd_data == model_before, "R8 idle read data", rd_data, model_before);
    cyc();
    check(rd_valid == 1'b0, "R8 blocked next cycle", {63'd0, rd_valid}, 64'd0);

    // R9: interlock on, wait 0
    cfg_wdata = {16'd0, 1'b1, 3'b111};
    cfg_we = 1'b1;
    cyc();
    cfg_we = 1'b0;
    repeat (6) cyc();
    for (int c = 0; c < 8; c++) begin
      cyc();
      check(rd_valid == 1'b1, "R9 wait zero", {63'd0, rd_valid}, 64'd1);
      check(rd_data == model_before, "R9 data", rd_data, model_before);
    end
    rd_req = 1'b0;
    cyc();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule